// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio N = B·P + A. It is the feedback path of a frequency synthesizer. A dual-modulus prescaler divides by either P or P+1. A main counter (B) counts prescaler cycles, and a swallow counter (A) keeps the prescaler in its longer P+1 mode for the first A of those cycles. When B has counted all of its cycles, the block emits a single-cycle pulse toward the phase detector. It then reloads both counters and the prescaler mode from the program inputs.

The prescaler base modulus P is 8 or 32, chosen by a select input. Program values are sampled only at a reload point, so software may rewrite them at any time without disturbing the division period already in progress. A synchronous counter-reset input holds every counter at its load state. This lets the divider restart in known alignment with a reference divider that is reset at the same time.

Top module: `pulse_swallow_div`

## Requirements
- R1: With the select input low (P = 8) and B ≥ A, consecutive output pulses are exactly 8·B + A input clock cycles apart.
- R2: With the select input high (P = 32) and B ≥ A, consecutive output pulses are exactly 32·B + A input clock cycles apart.
- R3: The output is low while the asynchronous reset is asserted. Each output pulse lasts exactly one input clock cycle.
- R4: While the counter-reset input is high, no output pulse appears, however long it is held.
- R5: The first output pulse after counter reset is released appears exactly N cycles after the first clock edge at which counter reset is low.
- R6: Changes to A, B or the select input during a period do not alter that period. They govern the next period, starting from the following reload.
- R7: A B value below 3 (legal range 3 to 8191) is treated as 3.
- R8: If A exceeds B, the prescaler stays at P+1 for the whole period, giving a period of B·(P+1) cycles.
- R9: With A = 0, the period is exactly B·P cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cntReset | input | 1 | Synchronous hold of all counters at load state |
| aVal | input | 5 | Swallow count A (0 to 31) |
| bVal | input | 13 | Main count B (3 to 8191) |
| pSel | input | 1 | Prescaler select: 0 gives 8/9, 1 gives 32/33 |
| divOut | output | 1 | One-cycle pulse per N input cycles |

## Verification
Two functions can fall in the same cycle. A reload may coincide with a fresh write of A, B and the select input, and the period that is ending must use the old values while the next one uses the new. The bench provokes this by rewriting all three inputs a few cycles into a period. It then measures the period in progress against the old ratio and the following period against the new ratio. The bench also asserts counter reset across many would-be reload points and checks that no pulse leaks out. After release, it checks that the first pulse lands exactly N cycles later.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // reload counters and prescaler mode from the program inputs
    logic stepB;  // main counter advances by one prescaler cycle
    logic stepA;  // swallow counter advances by one prescaler cycle
  } ctrl_t;
endpackage

// File: rtl/psd_datapath.sv
module psd_datapath
  import psd_pkg::*;
#(
  parameter int A_W   = 5,
  parameter int B_W   = 13,
  parameter int P_LO  = 8,
  parameter int P_HI  = 32,
  parameter int B_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ctrl_t          ctrl,
  input  logic [A_W-1:0] aVal,
  input  logic [B_W-1:0] bVal,
  input  logic           pSel,
  output logic           psEnd,
  output logic           aZero,
  output logic           bOne
);
  localparam int PS_W = $clog2(P_HI + 1);

  logic [PS_W-1:0] psCnt;
  logic [A_W-1:0]  aCnt;
  logic [B_W-1:0]  bCnt;
  logic            pReg;
  logic [B_W-1:0]  bEff;
  logic [PS_W-1:0] baseMod;
  logic [PS_W-1:0] modLast;

  // values under the legal minimum are raised to it
  assign bEff = (bVal < B_W'(B_MIN)) ? B_W'(B_MIN) : bVal;

  // prescaler terminal count: P+1 cycles while swallowing, P afterwards
  assign baseMod = pReg ? PS_W'(P_HI) : PS_W'(P_LO);
  assign modLast = aZero ? (baseMod - PS_W'(1)) : baseMod;

  assign psEnd = (psCnt == modLast);
  assign aZero = (aCnt == '0);
  assign bOne  = (bCnt == B_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psCnt <= '0;
      aCnt  <= '0;
      bCnt  <= B_W'(B_MIN);
      pReg  <= 1'b0;
    end else if (ctrl.load) begin
      psCnt <= '0;
      aCnt  <= aVal;
      bCnt  <= bEff;
      pReg  <= pSel;
    end else begin
      psCnt <= psEnd ? '0 : psCnt + PS_W'(1);
      if (ctrl.stepB) bCnt <= bCnt - B_W'(1);
      if (ctrl.stepA) aCnt <= aCnt - A_W'(1);
    end
  end

  // R1
  psCnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psCnt <= PS_W'(P_HI));

  // R7
  b_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl.load) |-> (bCnt >= B_W'(B_MIN)));

  // R6
  mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.load && !psEnd) |=> ($stable(aCnt) && $stable(bCnt) && $stable(pReg)));
endmodule

// File: rtl/psd_control.sv
module psd_control
  import psd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cntReset,
  input  logic  psEnd,
  input  logic  aZero,
  input  logic  bOne,
  output ctrl_t ctrl,
  output logic  divOut
);
  logic loadPend;
  logic reload;
  logic hold;

  assign hold   = cntReset | loadPend;
  assign reload = psEnd & bOne;

  always_comb begin
    ctrl.load  = hold | reload;
    ctrl.stepB = psEnd & ~bOne & ~hold;
    ctrl.stepA = psEnd & ~bOne & ~hold & ~aZero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadPend <= 1'b1;
      divOut   <= 1'b0;
    end else begin
      loadPend <= 1'b0;
      divOut   <= reload & ~hold;
    end
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divOut |=> !divOut);

  // R4
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cntReset |=> !divOut);
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int A_W   = 5,
  parameter int B_W   = 13,
  parameter int P_LO  = 8,
  parameter int P_HI  = 32,
  parameter int B_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cntReset,
  input  logic [A_W-1:0] aVal,
  input  logic [B_W-1:0] bVal,
  input  logic           pSel,
  output logic           divOut
);
  ctrl_t ctrl;
  logic  psEnd;
  logic  aZero;
  logic  bOne;

  psd_control u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cntReset (cntReset),
    .psEnd    (psEnd),
    .aZero    (aZero),
    .bOne     (bOne),
    .ctrl     (ctrl),
    .divOut   (divOut)
  );

  psd_datapath #(
    .A_W   (A_W),
    .B_W   (B_W),
    .P_LO  (P_LO),
    .P_HI  (P_HI),
    .B_MIN (B_MIN)
  ) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .ctrl  (ctrl),
    .aVal  (aVal),
    .bVal  (bVal),
    .pSel  (pSel),
    .psEnd (psEnd),
    .aZero (aZero),
    .bOne  (bOne)
  );
endmodule

// File: tb/pulse_swallow_div_tb.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cntReset = 1'b0;
  logic [4:0]  aVal = '0;
  logic [12:0] bVal = 13'd3;
  logic        pSel = 1'b0;
  logic        divOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_swallow_div u_dut (
    .clk(clk), .rst_n(rst_n), .cntReset(cntReset),
    .aVal(aVal), .bVal(bVal), .pSel(pSel), .divOut(divOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expN(input int a, input int b, input bit p);
    int bb = (b < 3) ? 3 : b;
    int pp = p ? 32 : 8;
    if (bb >= a) return bb * pp + a;
    return bb * (pp + 1);
  endfunction

  // cycles (negedge samples) until divOut is seen high
  task automatic nextPulse(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!divOut && cyc < 20000);
  endtask

  // program, pulse counter reset, release on a negedge
  task automatic setup(input int a, input int b, input bit p);
    @(negedge clk);
    aVal = 5'(a); bVal = 13'(b); pSel = p; cntReset = 1'b1;
    repeat (2) @(negedge clk);
    cntReset = 1'b0;
  endtask

  task automatic runCase(input int a, input int b, input bit p, input string req);
    int c;
    int n = expN(a, b, p);
    setup(a, b, p);
    nextPulse(c);
    check(c == n, "R5 first pulse after release", c, n);
    nextPulse(c);
    check(c == n, req, c, n);
    @(negedge clk);
    check(divOut == 1'b0, "R3 pulse width", int'(divOut), 0);
    nextPulse(c);
    check(c + 1 == n, req, c + 1, n);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c;
    int highs;
    int seed;
    seed = $urandom(32'h5A17);
    // R3: output low in reset
    repeat (3) @(negedge clk);
    check(divOut == 1'b0, "R3 reset state", int'(divOut), 0);
    rst_n = 1'b1;

    // directed cases
    runCase(5, 10, 1'b0, "R1 P=8");
    runCase(0, 7, 1'b0, "R9 A=0");
    runCase(0, 3, 1'b0, "R9 minimum B");
    runCase(31, 40, 1'b1, "R2 P=32");
    runCase(31, 31, 1'b1, "R2 A equals B");
    runCase(10, 4, 1'b0, "R8 A over B");
    runCase(0, 1, 1'b0, "R7 B clamp");
    runCase(2, 0, 1'b1, "R7 B zero clamp");

    // R4: long hold of counter reset, no pulse may appear
    @(negedge clk);
    aVal = 5'd0; bVal = 13'd3; pSel = 1'b0; cntReset = 1'b1;
    highs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (divOut) highs++;
    end
    check(highs == 0, "R4 hold", highs, 0);
    cntReset = 1'b0;
    nextPulse(c);
    check(c == 24, "R5 after long hold", c, 24);

    // R6: rewrite program mid-period
    setup(4, 10, 1'b0);
    nextPulse(c);
    repeat (5) @(negedge clk);
    aVal = 5'd2; bVal = 13'd20; pSel = 1'b1;
    nextPulse(c);
    check(c + 5 == 84, "R6 current period kept", c + 5, 84);
    nextPulse(c);
    check(c == 642, "R6 new period", c, 642);

    // random cases with B >= A
    for (int k = 0; k < 12; k++) begin
      int a = int'($urandom % 32);
      int b = a + int'($urandom % 20);
      bit p = bit'($urandom % 2);
      if (b < 3) b = 3;
      runCase(a, b, p, p ? "R2 random" : "R1 random");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule